// File: doc/BRIEF.md
# Shared Interrupt Source Controller

This block takes a bank of external interrupt request lines, conditions each one and steers it to one of a small set of core interrupt pins. Every line passes through a two-flop synchronizer. It is then read either as a level, with a configurable active sense, or as an edge that is caught in a sticky latch. An edge source may be set to catch one chosen edge or both edges. Software can also set or clear any edge latch by writing a single command word.

Each source has an enable bit. Software sets enable bits through one write port and clears them through another, so no read-modify-write is needed. A read-only view shows the enable bits, and a second read-only view shows the pending state of every source. A per-source routing word chooses the core pin that the source drives. A pin is raised when at least one source routed to it is both pending and enabled.

Software reaches the block through a plain 32-bit bus with word addresses. A write completes at the clock edge that samples `bus_wr_en_i`. A read returns data in `bus_rdata_o`, with `bus_rvalid_o` high, exactly one cycle after `bus_rd_en_i` is sampled. The bus has no back-pressure: the block accepts one access every cycle. Reads and writes must not be issued in the same cycle.

Top module: `irq_share_ctrl`

## Requirements
- R1: After reset the sense, edge-mode, both-edge and enable registers all read 0, `bus_rvalid_o` is low, and all core pins are low. With every input held low, every source therefore reads as pending, because it is an active-low level source.
- R2: A level source (edge-mode bit 0) is pending while its synchronized input equals its sense bit (1 = active-high, 0 = active-low). An input change appears in the pending view after two clock edges of synchronization.
- R3: An edge source (edge-mode bit 1, both-edge bit 0) latches pending on a rising input edge when its sense bit is 1, or on a falling edge when its sense bit is 0. The latch holds after the input returns, and the opposite edge does not set it.
- R4: An edge source whose both-edge bit is 1 latches pending on either a rising or a falling edge.
- R5: A write to the edge-command word (0x01C) carries a source number in bits 30:0. If bit 31 is 1, that source's edge latch is set; if bit 31 is 0, it is cleared. A number at or above the source count has no effect. A detected edge in the same cycle wins over a clear.
- R6: A 1 written to the enable-set port (bank 0x00C) enables that source, and a 1 written to the enable-clear port (bank 0x010) disables it. Zero bits leave the enable bit unchanged. Writes to the enable view (bank 0x014) are ignored.
- R7: Each register bank packs 32 sources per word. Source n sits in word (bank base + n/32), bit n%32. The banks are sense at 0x000, edge-mode at 0x004, both-edge at 0x008 and pending view at 0x018.
- R8: The routing word of source n is at 0x100+n. Bit 31 enables routing and bits 5:0 give the pin number. Core pin p is high when a source routed to pin p is pending and enabled. Routing with bit 31 at 0, or to a pin number at or above the pin count, drives no pin.
- R9: The core pins are registered. They change one clock edge after the enable or pending state that causes the change.
- R10: Read data and `bus_rvalid_o` appear exactly one cycle after `bus_rd_en_i` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_SRC | Raw interrupt request lines, asynchronous to clk_i |
| bus_wr_en_i | input | 1 | Write strobe |
| bus_rd_en_i | input | 1 | Read strobe |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read strobe |
| core_pin_o | output | NUM_PINS | Core interrupt pins |

## Verification
A corrupted edge latch shows in the pending view on the very next read. It also shows on the routed core pin one cycle after the bad latch value, provided the source is enabled. A wrong enable bit is visible immediately in the enable view, and on the pin one edge later. A routing field that decodes to the wrong pin lights a neighbouring pin, so the bench compares the whole pin vector and not just a single bit. Edge latches are checked both after the edge and after the input returns, so that a latch that only follows the input cannot pass.

// File: rtl/irq_share_pkg.sv
package irq_share_pkg;
  localparam int DATA_W       = 32;
  localparam int PIN_FIELD_W  = 6;
  localparam int ROUTE_EN_BIT = 31;
  localparam int SWE_SET_BIT  = 31;
  localparam int BANK_STRIDE  = 4;   // words reserved per bank (up to 128 sources)

  // word addresses
  localparam int REG_SENSE   = 0 * BANK_STRIDE;
  localparam int REG_EDGE    = 1 * BANK_STRIDE;
  localparam int REG_BOTH    = 2 * BANK_STRIDE;
  localparam int REG_EN_SET  = 3 * BANK_STRIDE;
  localparam int REG_EN_CLR  = 4 * BANK_STRIDE;
  localparam int REG_EN_VIEW = 5 * BANK_STRIDE;
  localparam int REG_PEND    = 6 * BANK_STRIDE;
  localparam int REG_SWE     = 7 * BANK_STRIDE;
  localparam int REG_ROUTE   = 256;

  typedef struct packed {
    logic                   en;
    logic [PIN_FIELD_W-1:0] pin;
  } route_t;
endpackage

// File: rtl/irq_share_src.sv
module irq_share_src (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic sense_i,
  input  logic edge_mode_i,
  input  logic both_i,
  input  logic sw_set_i,
  input  logic sw_clr_i,
  output logic pend_o
);
  logic sync1_q, sync2_q, prev_q, latch_q;
  logic rise, fall, det, level_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= raw_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign rise = sync2_q & ~prev_q;
  assign fall = ~sync2_q & prev_q;

  always_comb begin
    det = 1'b0;
    if (edge_mode_i) begin
      if (both_i) det = rise | fall;
      else        det = sense_i ? rise : fall;
    end
  end

  // hardware edge and software set take priority over a software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                latch_q <= 1'b0;
    else if (det || sw_set_i)   latch_q <= 1'b1;
    else if (sw_clr_i)          latch_q <= 1'b0;
  end

  assign level_hit = (sync2_q == sense_i);
  assign pend_o    = edge_mode_i ? latch_q : level_hit;

  assert_swclr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_clr_i && !sw_set_i && !det) |=> !latch_q);

  assert_latch_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latch_q) |-> $past(det || sw_set_i));
endmodule

// File: rtl/irq_share_regs.sv
module irq_share_regs #(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 10
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 wr_en_i,
  input  logic                                 rd_en_i,
  input  logic [ADDR_W-1:0]                    addr_i,
  input  logic [31:0]                          wdata_i,
  input  logic [NUM_SRC-1:0]                   pend_i,
  output logic [31:0]                          rdata_o,
  output logic                                 rvalid_o,
  output logic [NUM_SRC-1:0]                   sense_o,
  output logic [NUM_SRC-1:0]                   edge_o,
  output logic [NUM_SRC-1:0]                   both_o,
  output logic [NUM_SRC-1:0]                   en_o,
  output irq_share_pkg::route_t [NUM_SRC-1:0]  route_o,
  output logic [NUM_SRC-1:0]                   sw_set_o,
  output logic [NUM_SRC-1:0]                   sw_clr_o
);
  import irq_share_pkg::*;

  localparam int WORDS = (NUM_SRC + 31) / 32;
  localparam int PAD_W = WORDS * 32;

  logic [NUM_SRC-1:0] sense_q, edge_q, both_q, en_q;
  route_t [NUM_SRC-1:0] route_q;
  logic [WORDS-1:0] wr_sense, wr_edge, wr_both, wr_eset, wr_eclr;
  logic [NUM_SRC-1:0] wr_route, eset_req, eclr_req;
  logic swe_wr;
  logic [31:0] rdata_q, rd_next;
  logic rvalid_q;

  for (genvar w = 0; w < WORDS; w++) begin : g_wdec
    assign wr_sense[w] = wr_en_i && (addr_i == ADDR_W'(REG_SENSE  + w));
    assign wr_edge[w]  = wr_en_i && (addr_i == ADDR_W'(REG_EDGE   + w));
    assign wr_both[w]  = wr_en_i && (addr_i == ADDR_W'(REG_BOTH   + w));
    assign wr_eset[w]  = wr_en_i && (addr_i == ADDR_W'(REG_EN_SET + w));
    assign wr_eclr[w]  = wr_en_i && (addr_i == ADDR_W'(REG_EN_CLR + w));
  end

  assign swe_wr = wr_en_i && (addr_i == ADDR_W'(REG_SWE));

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_sdec
    assign wr_route[s] = wr_en_i && (addr_i == ADDR_W'(REG_ROUTE + s));
    assign eset_req[s] = wr_eset[s/32] & wdata_i[s%32];
    assign eclr_req[s] = wr_eclr[s/32] & wdata_i[s%32];
    assign sw_set_o[s] = swe_wr &  wdata_i[SWE_SET_BIT] && (wdata_i[30:0] == 31'(s));
    assign sw_clr_o[s] = swe_wr & ~wdata_i[SWE_SET_BIT] && (wdata_i[30:0] == 31'(s));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_q <= '0;
      edge_q  <= '0;
      both_q  <= '0;
      en_q    <= '0;
      route_q <= '0;
    end else begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (wr_sense[s/32]) sense_q[s] <= wdata_i[s%32];
        if (wr_edge[s/32])  edge_q[s]  <= wdata_i[s%32];
        if (wr_both[s/32])  both_q[s]  <= wdata_i[s%32];
        if (eset_req[s])    en_q[s]    <= 1'b1;
        if (eclr_req[s])    en_q[s]    <= 1'b0;
        if (wr_route[s]) begin
          route_q[s].en  <= wdata_i[ROUTE_EN_BIT];
          route_q[s].pin <= wdata_i[PIN_FIELD_W-1:0];
        end
      end
    end
  end

  logic [PAD_W-1:0] sense_pad, edge_pad, both_pad, en_pad, pend_pad;
  assign sense_pad = PAD_W'(sense_q);
  assign edge_pad  = PAD_W'(edge_q);
  assign both_pad  = PAD_W'(both_q);
  assign en_pad    = PAD_W'(en_q);
  assign pend_pad  = PAD_W'(pend_i);

  always_comb begin
    rd_next = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (addr_i == ADDR_W'(REG_SENSE   + w)) rd_next = sense_pad[w*32 +: 32];
      if (addr_i == ADDR_W'(REG_EDGE    + w)) rd_next = edge_pad[w*32 +: 32];
      if (addr_i == ADDR_W'(REG_BOTH    + w)) rd_next = both_pad[w*32 +: 32];
      if (addr_i == ADDR_W'(REG_EN_VIEW + w)) rd_next = en_pad[w*32 +: 32];
      if (addr_i == ADDR_W'(REG_PEND    + w)) rd_next = pend_pad[w*32 +: 32];
    end
    for (int s = 0; s < NUM_SRC; s++) begin
      if (addr_i == ADDR_W'(REG_ROUTE + s))
        rd_next = {route_q[s].en, {(31-PIN_FIELD_W){1'b0}}, route_q[s].pin};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en_i;
      if (rd_en_i) rdata_q <= rd_next;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign sense_o  = sense_q;
  assign edge_o   = edge_q;
  assign both_o   = both_q;
  assign en_o     = en_q;
  assign route_o  = route_q;

  assert_en_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|eset_req) |=> ((en_q & $past(eset_req)) == $past(eset_req)));

  assert_en_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|eclr_req) |=> ((en_q & $past(eclr_req)) == '0));

  assert_en_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|eset_req) && !(|eclr_req)) |=> $stable(en_q));

  assert_rvalid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_q);
endmodule

// File: rtl/irq_share_router.sv
module irq_share_router #(
  parameter int NUM_SRC  = 64,
  parameter int NUM_PINS = 6
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [NUM_SRC-1:0]                  active_i,
  input  irq_share_pkg::route_t [NUM_SRC-1:0] route_i,
  output logic [NUM_PINS-1:0]                 pin_o
);
  import irq_share_pkg::*;

  logic [NUM_PINS-1:0] hit, pin_q;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_comb begin
      hit[p] = 1'b0;
      for (int s = 0; s < NUM_SRC; s++) begin
        if (active_i[s] && route_i[s].en && (route_i[s].pin == PIN_FIELD_W'(p)))
          hit[p] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= '0;
    else         pin_q <= hit;
  end

  assign pin_o = pin_q;

  assert_pin_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pin_q) |-> $past(|active_i));
endmodule

// File: rtl/irq_share_ctrl.sv
module irq_share_ctrl #(
  parameter int NUM_SRC  = 64,
  parameter int NUM_PINS = 6,
  parameter int ADDR_W   = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC-1:0]  irq_i,
  input  logic                bus_wr_en_i,
  input  logic                bus_rd_en_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [31:0]         bus_wdata_i,
  output logic [31:0]         bus_rdata_o,
  output logic                bus_rvalid_o,
  output logic [NUM_PINS-1:0] core_pin_o
);
  import irq_share_pkg::*;

  logic [NUM_SRC-1:0] sense, edge_mode, both, en, sw_set, sw_clr, pend;
  route_t [NUM_SRC-1:0] route;

  irq_share_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) regs_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (bus_wr_en_i),
    .rd_en_i  (bus_rd_en_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .pend_i   (pend),
    .rdata_o  (bus_rdata_o),
    .rvalid_o (bus_rvalid_o),
    .sense_o  (sense),
    .edge_o   (edge_mode),
    .both_o   (both),
    .en_o     (en),
    .route_o  (route),
    .sw_set_o (sw_set),
    .sw_clr_o (sw_clr)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    irq_share_src src_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .raw_i       (irq_i[s]),
      .sense_i     (sense[s]),
      .edge_mode_i (edge_mode[s]),
      .both_i      (both[s]),
      .sw_set_i    (sw_set[s]),
      .sw_clr_i    (sw_clr[s]),
      .pend_o      (pend[s])
    );
  end

  irq_share_router #(.NUM_SRC(NUM_SRC), .NUM_PINS(NUM_PINS)) router_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (pend & en),
    .route_i  (route),
    .pin_o    (core_pin_o)
  );

  assert_sw_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sw_set | sw_clr));
endmodule

// File: tb/irq_share_ctrl_tb_top.sv
module irq_share_ctrl_tb_top;
  localparam int NS = 64, NP = 6, AW = 10;
  localparam int A_SENSE = 0, A_EDGE = 4, A_BOTH = 8, A_ESET = 12, A_ECLR = 16;
  localparam int A_EVIEW = 20, A_PEND = 24, A_SWE = 28, A_ROUTE = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0] irq = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic rvalid;
  logic [NP-1:0] pins;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4ns clk = ~clk;

  irq_share_ctrl #(.NUM_SRC(NS), .NUM_PINS(NP), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .bus_wr_en_i(wr_en),
    .bus_rd_en_i(rd_en), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .bus_rvalid_o(rvalid), .core_pin_o(pins));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    check("R10 rvalid", 32'(rvalid), 32'd1);
    d = rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 rvalid idle", 32'(rvalid), 32'd0);
    check("R1 pins", 32'(pins), 32'd0);
    rd(A_SENSE, d); check("R1 sense", d, 32'd0);
    rd(A_EDGE + 1, d); check("R1 edge", d, 32'd0);
    rd(A_BOTH, d); check("R1 both", d, 32'd0);
    rd(A_EVIEW + 1, d); check("R1 enable", d, 32'd0);
    rd(A_PEND, d); check("R1 pend w0", d, 32'hFFFF_FFFF);
    rd(A_PEND + 1, d); check("R1 pend w1", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(A_SENSE, 32'hFFFF_FFFF);
    wr(A_SENSE + 1, 32'hFFFF_FFFF);
    settle();
    rd(A_PEND, d); check("R2 active-high idle", d, 32'd0);
    irq[40] = 1'b1;
    settle();
    rd(A_PEND + 1, d); check("R7 source 40 word1 bit8", d, 32'h0000_0100);
    rd(A_PEND, d); check("R7 word0 untouched", d, 32'd0);
    irq[40] = 1'b0;
    settle();
    rd(A_PEND + 1, d); check("R2 level follows input", d, 32'd0);
    wr(A_SENSE + 1, 32'hFFFF_FEFF);
    settle();
    rd(A_PEND + 1, d); check("R2 active-low level", d, 32'h0000_0100);
    wr(A_SENSE + 1, 32'hFFFF_FFFF);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(A_EDGE, 32'hFFFF_FFFF);
    irq[3] = 1'b1;
    settle();
    rd(A_PEND, d); check("R3 rising latched", d, 32'h0000_0008);
    irq[3] = 1'b0;
    settle();
    rd(A_PEND, d); check("R3 latch holds", d, 32'h0000_0008);
    wr(A_SWE, 32'd3);
    settle();
    rd(A_PEND, d); check("R5 clear", d, 32'd0);
    irq[3] = 1'b1; settle();
    wr(A_SWE, 32'd3); settle();
    irq[3] = 1'b0; settle();
    rd(A_PEND, d); check("R3 falling ignored", d, 32'd0);
  endtask

  task automatic t_both();
    logic [31:0] d;
    wr(A_BOTH, 32'h0000_0080);
    irq[7] = 1'b1; settle();
    rd(A_PEND, d); check("R4 rise", d, 32'h0000_0080);
    wr(A_SWE, 32'd7); settle();
    rd(A_PEND, d); check("R4 cleared", d, 32'd0);
    irq[7] = 1'b0; settle();
    rd(A_PEND, d); check("R4 fall", d, 32'h0000_0080);
    wr(A_SWE, 32'd7);
  endtask

  task automatic t_swedge();
    logic [31:0] d;
    wr(A_SWE, 32'h8000_000A); settle();
    rd(A_PEND, d); check("R5 set src10", d, 32'h0000_0400);
    wr(A_SWE, 32'h8000_00C8); settle();
    rd(A_PEND, d); check("R5 out of range w0", d, 32'h0000_0400);
    rd(A_PEND + 1, d); check("R5 out of range w1", d, 32'd0);
    wr(A_SWE, 32'h0000_000A); settle();
    rd(A_PEND, d); check("R5 clear src10", d, 32'd0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(A_ESET, 32'h0000_00F0);
    rd(A_EVIEW, d); check("R6 set", d, 32'h0000_00F0);
    wr(A_ESET, 32'h0000_0001);
    rd(A_EVIEW, d); check("R6 zeros keep", d, 32'h0000_00F1);
    wr(A_ECLR, 32'h0000_0030);
    rd(A_EVIEW, d); check("R6 clear", d, 32'h0000_00C1);
    wr(A_EVIEW, 32'hFFFF_FFFF);
    rd(A_EVIEW, d); check("R6 view read-only", d, 32'h0000_00C1);
    rd(A_EVIEW + 1, d); check("R6 word1 untouched", d, 32'd0);
  endtask

  task automatic t_route();
    logic [31:0] d;
    wr(A_ROUTE + 40, 32'h8000_0002);
    rd(A_ROUTE + 40, d); check("R8 route readback", d, 32'h8000_0002);
    irq[40] = 1'b1; settle();
    check("R8 disabled source", 32'(pins), 32'd0);
    wr(A_ESET + 1, 32'h0000_0100);
    check("R9 not yet", 32'(pins), 32'd0);
    @(negedge clk);
    check("R9 one edge later", 32'(pins), 32'h04);
    wr(A_ROUTE + 40, 32'h0000_0002); settle();
    check("R8 routing off", 32'(pins), 32'd0);
    wr(A_ROUTE + 40, 32'h8000_0007); settle();
    check("R8 pin out of range", 32'(pins), 32'd0);
    wr(A_ROUTE + 40, 32'h8000_0005); settle();
    check("R8 pin5", 32'(pins), 32'h20);
    wr(A_ROUTE + 41, 32'h8000_0005);
    wr(A_ESET + 1, 32'h0000_0200);
    irq[41] = 1'b1; settle();
    irq[40] = 1'b0; settle();
    check("R8 shared pin other source", 32'(pins), 32'h20);
    wr(A_ECLR + 1, 32'h0000_0200); settle();
    check("R8 all disabled", 32'(pins), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_level();
    t_edge();
    t_both();
    t_swedge();
    t_enable();
    t_route();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule